// File: doc/BRIEF.md
# Serial Presence Detect EEPROM

This block is a synthesizable model of the 256-byte configuration EEPROM that a memory module carries. Over a two-wire I2C bus it answers as a target. A host reads the module description from it, and it also gives the host a small scratch area it can write. The block samples SCL and SDA with the system clock and finds bus conditions and bit edges from those samples. Toward SDA it drives only a pull-low enable. The bus pull-up and the wired-AND of the line are outside the block.

The target answers one 7-bit address. Its upper four bits are a parameter and its lower three bits come from three board strap inputs. A write transfer carries a word address and then any number of data bytes. A read transfer returns bytes from the word pointer, and a repeated START between the two gives a random read. The array gets its contents at reset from parameters. The low half holds a description profile, one byte of which is the checksum of the bytes below it. The high half is filled with a fixed value for system use. A write-protect input freezes the array. After a write is committed, the target stays off the bus for a programmable internal write time.

Top module: `spd_eeprom`

## Requirements
- R1: A START or repeated START is an SDA fall while SCL is high, and a STOP is an SDA rise while SCL is high. A repeated START drops the transfer in progress and begins address matching again, and the word pointer keeps its value.
- R2: The target acknowledges an address byte only if its upper seven bits equal {DEV_BASE, strap_i} (bit 0 is 1 for a read). On a mismatch it leaves SDA released until the next START.
- R3: In a write transfer, the first byte after the address is acknowledged and loaded into the word pointer.
- R4: Each further written byte is acknowledged and stored at the word pointer. The pointer then steps up by one and wraps from 255 to 0.
- R5: Read bytes are sent MSB first, starting from the word pointer, and the pointer steps up by one and wraps after each byte. A master ACK (SDA low in the ninth clock) starts the next byte. A master NACK ends the read and leaves SDA released.
- R6: While wp_i is high, data bytes are still acknowledged but the array does not change, and no internal write time starts.
- R7: A STOP that ends a transfer which stored at least one byte starts an internal write time of WRITE_CYCLES clocks. During that time the target does not acknowledge its address. Afterwards it answers again.
- R8: After reset, bytes 0 to 15 hold PROFILE (byte i at bits 8i+7:8i), bytes 16 to 127 hold 0x00 except byte 63, bytes 128 to 255 hold FILL, and byte 63 equals the sum of bytes 0 to 62 modulo 256.
- R9: The target changes sda_pull_o only while SCL is low, so anything it drives holds steady through the SCL high phase.
- R10: While reset is held, sda_pull_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low reset; reloads the array image |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| sda_pull_o | output | 1 | High to pull SDA low (open-drain drive) |
| strap_i | input | 3 | Board straps, low three bits of the device address |
| wp_i | input | 1 | High blocks all array updates |

## Verification
The bench targets the pointer wrap at the top of the array, on writes and on sequential reads. A design that saturates the pointer or fails to carry it would store or return the wrong byte at address 0. It addresses the target again immediately after a committed write. A target that ignores its own write time would acknowledge there, and one that arms the timer on a write-protected transfer would refuse the next address. The bench also reads the whole description area and checks byte 63 against a sum it computes itself, so an image built with the wrong checksum range, or with the halves swapped, shows up as a data mismatch. A mismatched address followed by a data byte shows whether a non-selected target stays quiet.

// File: rtl/spd_pkg.sv
package spd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_AACK,
    ST_WORD,
    ST_WACK,
    ST_WDATA,
    ST_DACK,
    ST_RD,
    ST_RACK
  } spd_state_e;

endpackage

// File: rtl/spd_line_sync.sv
module spd_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_p  = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_p   = scl_s & scl_d & sda_s & ~sda_d;

endmodule

// File: rtl/spd_busy_timer.sv
module spd_busy_timer #(
  parameter int CYCLES = 1500000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic busy_o
);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (arm) begin
      left_q <= CW'(CYCLES);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign busy_o = (left_q != '0);

endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter int                  BYTES   = 256,
  parameter int                  PROF_N  = 16,
  parameter logic [8*PROF_N-1:0] PROFILE = '0,
  parameter logic [7:0]          FILL    = 8'hFF,
  parameter int                  CSUM_AT = 63,
  localparam int AW = $clog2(BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [AW-1:0]      addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [8*BYTES-1:0] image_o
);

  function automatic logic [7:0] seed_byte(int idx);
    if (idx < PROF_N)         return PROFILE[8*idx +: 8];
    else if (idx < BYTES / 2) return 8'h00;
    else                      return FILL;
  endfunction

  function automatic logic [7:0] seed_sum();
    logic [7:0] acc;
    acc = 8'h00;
    for (int k = 0; k < CSUM_AT; k++) acc = acc + seed_byte(k);
    return acc;
  endfunction

  localparam logic [7:0] CSUM_VAL = seed_sum();

  function automatic logic [7:0] boot_byte(int idx);
    return (idx == CSUM_AT) ? CSUM_VAL : seed_byte(idx);
  endfunction

  logic [7:0] mem_q [BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < BYTES; k++) mem_q[k] <= boot_byte(k);
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];

  generate
    for (genvar g = 0; g < BYTES; g++) begin : g_img
      assign image_o[8*g +: 8] = mem_q[g];
    end
  endgenerate

endmodule

// File: rtl/spd_engine.sv
module spd_engine import spd_pkg::*; #(
  parameter int         AW       = 8,
  parameter logic [3:0] DEV_BASE = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          sda_s,
  input  logic          start_p,
  input  logic          stop_p,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  input  logic          busy_i,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [7:0]    wdata_o,
  output logic          arm_o,
  output logic          pull_o,
  output spd_state_e    state_o,
  output logic [7:0]    shift_o
);

  spd_state_e   state_q;
  logic [2:0]   cnt_q;
  logic         full_q;
  logic [7:0]   sh_q;
  logic [AW-1:0] ptr_q;
  logic         pull_q;
  logic         rw_q;
  logic         wrote_q;
  logic         mack_q;

  logic shifting;
  logic byte_done;
  logic dev_hit;

  assign shifting  = (state_q == ST_DEV) || (state_q == ST_WORD) || (state_q == ST_WDATA);
  assign byte_done = shifting && scl_fall && full_q;
  assign dev_hit   = (sh_q[7:1] == {DEV_BASE, strap_i}) && !busy_i;

  assign we_o    = (state_q == ST_WDATA) && byte_done && !wp_i;
  assign wdata_o = sh_q;
  assign ptr_o   = ptr_q;
  assign arm_o   = stop_p && wrote_q;
  assign pull_o  = pull_q;
  assign state_o = state_q;
  assign shift_o = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      ptr_q   <= '0;
      pull_q  <= 1'b0;
      rw_q    <= 1'b0;
      wrote_q <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start_p) begin
      state_q <= ST_DEV;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      pull_q  <= 1'b0;
    end else if (stop_p) begin
      state_q <= ST_IDLE;
      pull_q  <= 1'b0;
      wrote_q <= 1'b0;
    end else begin
      case (state_q)
        ST_DEV, ST_WORD, ST_WDATA: begin
          if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == 3'd7) full_q <= 1'b1;
          end else if (byte_done) begin
            full_q <= 1'b0;
            cnt_q  <= '0;
            if (state_q == ST_DEV) begin
              if (dev_hit) begin
                pull_q  <= 1'b1;
                rw_q    <= sh_q[0];
                state_q <= ST_AACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else if (state_q == ST_WORD) begin
              ptr_q   <= sh_q[AW-1:0];
              pull_q  <= 1'b1;
              state_q <= ST_WACK;
            end else begin
              ptr_q   <= ptr_q + 1'b1;
              wrote_q <= wrote_q | !wp_i;
              pull_q  <= 1'b1;
              state_q <= ST_DACK;
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              sh_q    <= rdata;
              pull_q  <= ~rdata[7];
              cnt_q   <= '0;
              state_q <= ST_RD;
            end else begin
              pull_q  <= 1'b0;
              state_q <= ST_WORD;
            end
          end
        end
        ST_WACK, ST_DACK: begin
          if (scl_fall) begin
            pull_q  <= 1'b0;
            state_q <= ST_WDATA;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 3'd7) begin
              pull_q  <= 1'b0;
              ptr_q   <= ptr_q + 1'b1;
              state_q <= ST_RACK;
            end else begin
              cnt_q  <= cnt_q + 1'b1;
              sh_q   <= {sh_q[6:0], 1'b0};
              pull_q <= ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_q    <= rdata;
              pull_q  <= ~rdata[7];
              cnt_q   <= '0;
              state_q <= ST_RD;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spd_eeprom.sv
module spd_eeprom import spd_pkg::*; #(
  parameter logic [3:0]   DEV_BASE     = 4'b1010,
  parameter int           MEM_BYTES    = 256,
  parameter int           WRITE_CYCLES = 1500000,
  parameter int           SYNC_STAGES  = 2,
  parameter logic [127:0] PROFILE      = 128'h0100_0880_0060_A001_0048_020A_0C04_0880,
  parameter logic [7:0]   FILL         = 8'hFF,
  parameter int           CSUM_AT      = 63
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] strap_i,
  input  logic       wp_i
);

  localparam int AW = $clog2(MEM_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  logic busy, arm, we;
  logic [AW-1:0] ptr;
  logic [7:0] wdata, rdata, shift;
  logic [8*MEM_BYTES-1:0] image;
  spd_state_e state;

  spd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  spd_engine #(.AW(AW), .DEV_BASE(DEV_BASE)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_p(start_p), .stop_p(stop_p), .strap_i(strap_i),
    .wp_i(wp_i), .busy_i(busy), .rdata(rdata), .ptr_o(ptr), .we_o(we),
    .wdata_o(wdata), .arm_o(arm), .pull_o(sda_pull_o), .state_o(state),
    .shift_o(shift)
  );

  spd_busy_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .arm(arm), .busy_o(busy)
  );

  spd_store #(
    .BYTES(MEM_BYTES), .PROF_N(16), .PROFILE(PROFILE),
    .FILL(FILL), .CSUM_AT(CSUM_AT)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(ptr), .wdata(wdata),
    .rdata(rdata), .image_o(image)
  );

endmodule

// File: rtl/spd_checker.sv
module spd_checker import spd_pkg::*; #(
  parameter int         IMG_W    = 2048,
  parameter logic [3:0] DEV_BASE = 4'b1010
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_p,
  input logic             busy,
  input logic             wp_i,
  input logic [2:0]       strap_i,
  input logic             sda_pull_o,
  input spd_state_e       state,
  input logic [7:0]       shift,
  input logic [IMG_W-1:0] image
);

  // R9: drive changes only follow a low SCL sample
  p_drive_in_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !$past(scl_s));

  // R5 and R2: the target pulls only while acknowledging or sending data
  p_drive_states_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_o |-> (state == ST_AACK || state == ST_WACK ||
                    state == ST_DACK || state == ST_RD));

  // R2: an address acknowledge implies the captured address matched
  p_addr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AACK) |-> (shift[7:1] == {DEV_BASE, strap_i}));

  // R7: no address acknowledge during the internal write time
  p_busy_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (state != ST_AACK));

  // R7: the write time starts only from a STOP
  p_busy_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_p));

  // R6: protected array never changes
  p_wp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |=> $stable(image));

endmodule

bind spd_eeprom spd_checker #(.IMG_W(8*MEM_BYTES), .DEV_BASE(DEV_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_p(stop_p), .busy(busy),
  .wp_i(wp_i), .strap_i(strap_i), .sda_pull_o(sda_pull_o), .state(state),
  .shift(shift), .image(image)
);

// File: tb/tb_spd_eeprom.sv
module tb_spd_eeprom;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;
  localparam int WR_CYC     = 400;
  localparam logic [127:0] PROF = 128'h0100_0880_0060_A001_0048_020A_0C04_0880;
  localparam logic [7:0]   FILLV = 8'hFF;
  localparam logic [2:0]   STRAP = 3'b101;
  localparam logic [7:0]   DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0]   DEV_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_pull = 1'b0;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  assign sda_line = !(m_pull || sda_pull);

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_eeprom #(.WRITE_CYCLES(WR_CYC), .PROFILE(PROF), .FILL(FILLV)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .strap_i(STRAP), .wp_i(wp)
  );

  function automatic logic [7:0] ref_byte(int idx);
    logic [7:0] acc;
    if (idx == 63) begin
      acc = 8'h00;
      for (int k = 0; k < 63; k++) acc = acc + ref_byte(k);
      return acc;
    end
    if (idx < 16)  return PROF[8*idx +: 8];
    if (idx < 128) return 8'h00;
    return FILLV;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_byte(input logic [7:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (obs_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        if (exp_q.size() > 0) begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(o == e, t, o, e);
        end else begin
          check(1'b0, "scoreboard underrun", o, 0);
        end
      end
    end
  end

  task automatic bit_cycle(input logic drive_low, output logic seen);
    m_pull = drive_low;
    ticks(Q);
    scl = 1'b1;
    ticks(Q);
    seen = sda_line;
    ticks(Q);
    scl = 1'b0;
    ticks(Q);
  endtask

  task automatic bus_start();
    m_pull = 1'b0;
    ticks(Q);
    scl = 1'b1;
    ticks(2*Q);
    m_pull = 1'b1;
    ticks(2*Q);
    scl = 1'b0;
    ticks(Q);
  endtask

  task automatic bus_stop();
    m_pull = 1'b1;
    ticks(Q);
    scl = 1'b1;
    ticks(2*Q);
    m_pull = 1'b0;
    ticks(4*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(~b[i], s);
    bit_cycle(1'b0, s);
    ack = !s;
  endtask

  task automatic recv_byte(input logic give_ack);
    logic s;
    logic [7:0] b;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b0, s);
      b = {b[6:0], s};
    end
    bit_cycle(give_ack, s);
    obs_q.push_back(b);
  endtask

  task automatic point_to(input logic [7:0] a);
    logic ack;
    bus_start();
    send_byte(DEV_W, ack);
    check(ack, "R2 address ack (write)", ack, 1);
    send_byte(a, ack);
    check(ack, "R3 word address ack", ack, 1);
  endtask

  task automatic read_run(input logic [7:0] a, input int n);
    logic ack;
    point_to(a);
    bus_start();
    send_byte(DEV_R, ack);
    check(ack, "R1 address ack after repeated START", ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1);
    ticks(Q);
    check(sda_pull == 1'b0, "R5 released after master NACK", sda_pull, 0);
    bus_stop();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    ticks(200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic ack;
    ticks(5);
    check(sda_pull == 1'b0, "R10 reset drive", sda_pull, 0);
    rst_n = 1'b1;
    ticks(10);

    // R2: wrong address, then silence for a following byte
    bus_start();
    send_byte(8'hA0, ack);
    check(!ack, "R2 mismatch NACK", ack, 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 silent until next START", ack, 0);
    bus_stop();

    // R8: description area and checksum via sequential read
    for (int i = 0; i < 64; i++) expect_byte(ref_byte(i), (i == 63) ? "R8 checksum byte" : "R8 image byte");
    read_run(8'h00, 64);
    expect_byte(8'h00, "R8 low half byte 127");
    expect_byte(FILLV, "R8 high half byte 128");
    read_run(8'h7F, 2);

    // R4 then R7: write, busy NACK, then answered again
    point_to(8'h90);
    send_byte(8'h5A, ack);
    check(ack, "R4 data ack", ack, 1);
    bus_stop();
    bus_start();
    send_byte(DEV_W, ack);
    check(!ack, "R7 NACK during write time", ack, 0);
    bus_stop();
    ticks(WR_CYC + 100);
    expect_byte(8'h5A, "R4 stored byte");
    read_run(8'h90, 1);

    // R4 and R5: wrap from 255 to 0
    point_to(8'hFF);
    send_byte(8'h11, ack);
    check(ack, "R4 data ack at 255", ack, 1);
    send_byte(8'h22, ack);
    check(ack, "R4 data ack after wrap", ack, 1);
    bus_stop();
    ticks(WR_CYC + 100);
    expect_byte(8'h11, "R4 byte 255");
    expect_byte(8'h22, "R5 read wrap to byte 0");
    read_run(8'hFF, 2);

    // R6: write protect
    wp = 1'b1;
    point_to(8'h90);
    send_byte(8'h33, ack);
    check(ack, "R6 protected data still acked", ack, 1);
    bus_stop();
    bus_start();
    send_byte(DEV_W, ack);
    check(ack, "R6 no write time after protected write", ack, 1);
    bus_stop();
    wp = 1'b0;
    expect_byte(8'h5A, "R6 array unchanged");
    read_run(8'h90, 1);

    ticks(20);
    while (obs_q.size() > 0) ticks(1);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule